// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave-side command engine of a small serial memory on a four-wire SPI link. While the select line is low, it takes one command byte and then address or data bytes on the serial clock. Read data and status go out on a serial output that has its own output-enable. A write-enable latch must be set before any write is accepted. Bytes for a page write are held in a page buffer. A programming cycle, timed in system clocks, copies the buffer into an on-chip byte array, and during that cycle the busy bit is set and every command except the status read is refused.

All serial inputs are synchronised and oversampled by the system clock. The link uses SPI mode 0: input bits are taken on the rising serial-clock edge and output bits change on the falling edge. A pause input freezes a transfer part-way through without deselecting the device. The synchronous reset stands in for power-on reset: it leaves the block idle, with writes disabled and the status clear.

Top module: `spi_eeprom_ctl`

## Requirements
- R1: After reset the output-enable is 0, and both the write-enable latch (status bit 1) and the busy flag (status bit 0) read 0, so the status byte reads 0x00.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte MSB first and repeats it with live contents for every further byte clocked.
- R3: A data write (0x02) or status write (0x01) issued while the write-enable latch is clear is dropped, and neither the memory nor the status changes.
- R4: Command 0x03 is followed by a 16-bit address, MSB first, of which only the low ADDR_W bits are used. Data leaves MSB first, changing after falling serial-clock edges, and the address increments for each further byte.
- R5: With the latch set, a data write stores its data bytes, which become readable after the programming cycle that starts when the select line rises.
- R6: Consecutive data bytes of one write wrap around inside the aligned 2^PAGE_W-byte page that holds the start address.
- R7: When a data or status programming cycle completes, the write-enable latch clears by itself.
- R8: The busy flag stays set for WR_CYCLES system clocks. While it is set, only the status read is executed and every other command is ignored, including its output.
- R9: If the select line rises anywhere except right after a whole data byte, the write is abandoned: busy never sets and the latch keeps its value.
- R10: An unknown command byte is ignored, and the output-enable stays 0 for the rest of that select period.
- R11: Taking the pause input low while the serial clock is low disables the output and makes the block ignore serial clock edges. Releasing it while the serial clock is low resumes the transfer at the bit where it stopped.
- R12: A completed status write loads data bits 7:2 into status bits 7:2. Bits 1:0 always show the latch and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sel_n | input | 1 | Device select, active low |
| ser_clk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| pause_n | input | 1 | Transfer pause, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output-enable for miso (0 = high impedance) |

## Verification
On every cycle, the assertions check the following:
- A pause always disables the output and freezes the bit counter.
- Busy only begins while the write-enable latch is set, and the latch always clears after a completed programming cycle.
- A command refused during busy, or an unknown command, ends in the ignore state with the output disabled.
- An off-boundary deselect never starts programming.

Only the bench's scenarios can show the following:
- The data actually returned for a given address, including address truncation and page wrap-around.
- A transfer resuming at the right bit after a pause.
- A status write taking effect.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [3:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RDAT, ST_WDAT,
    ST_SRDAT, ST_SRFULL, ST_STAT, ST_IGN
  } cmd_st_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_wr_timer.sv
module spi_wr_timer #(
  parameter int CYCLES = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  output logic                      busy,
  output logic [$clog2(CYCLES)-1:0] step,
  output logic                      done
);
  localparam int CW = $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign step = cnt;

  // R8: the busy window closes after its last count
  p_timer_end_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> (!busy && done))
    else $error("busy did not end after last count");
endmodule

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl import spi_mem_pkg::*; #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic ser_clk,
  input  logic mosi,
  input  logic pause_n,
  output logic miso,
  output logic miso_oe
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int BASE_W     = ADDR_W - PAGE_W;
  localparam int CW         = $clog2(WR_CYCLES);

  // input synchronisation and edge detection
  logic sel_s, pause_s, mosi_s, sck_s, sck_d, sel_d;
  spi_in_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst),
    .d({sel_n, pause_n, mosi, ser_clk}),
    .q({sel_s, pause_s, mosi_s, sck_s})
  );

  logic paused;
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      sel_d  <= 1'b1;
      paused <= 1'b0;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel_s;
      if (sel_s)       paused <= 1'b0;
      else if (!sck_s) paused <= !pause_s;
    end
  end

  logic clk_rise, clk_fall, sel_rise;
  assign clk_rise = sck_s & ~sck_d & ~sel_s & ~paused;
  assign clk_fall = ~sck_s & sck_d & ~sel_s & ~paused;
  assign sel_rise = sel_s & ~sel_d;

  // command state
  cmd_st_t           st;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sr;
  logic [7:0]        rx_byte;
  logic              byte_done;
  logic              wel, is_rd, page_got, rd_req, rd_cap;
  logic              wr_start, wr_is_page, busy, wr_done;
  logic [5:0]        sr_user, sr_new;
  logic [HI_W-1:0]   ahi;
  logic [ADDR_W-1:0] addr, full_a;
  logic [BASE_W-1:0] pg_base;
  logic [PAGE_W-1:0] pg_col, cidx;
  logic [PAGE_BYTES-1:0] pg_vld;
  logic [7:0]        tx_byte, status, ram_rdata;
  logic [CW-1:0]     step;

  assign rx_byte   = {rx_sr, mosi_s};
  assign byte_done = clk_rise && (bit_cnt == 3'd7);
  assign full_a    = {ahi, rx_byte};
  assign status    = {sr_user, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OPC;  bit_cnt <= '0;  rx_sr <= '0;  wel <= 1'b0;
      sr_user <= '0; sr_new <= '0;   ahi <= '0;    addr <= '0;
      pg_base <= '0; pg_col <= '0;   pg_vld <= '0; page_got <= 1'b0;
      is_rd <= 1'b0; tx_byte <= '0;  rd_req <= 1'b0; rd_cap <= 1'b0;
      wr_start <= 1'b0; wr_is_page <= 1'b0;
    end else begin
      wr_start <= 1'b0;
      rd_req   <= 1'b0;
      rd_cap   <= rd_req;
      if (rd_cap) tx_byte <= ram_rdata;
      if (sel_s) begin
        st      <= ST_OPC;
        bit_cnt <= '0;
        if (sel_rise) begin
          if (st == ST_WDAT && bit_cnt == 3'd0 && page_got) begin
            wr_start <= 1'b1; wr_is_page <= 1'b1;
          end else if (st == ST_SRFULL) begin
            wr_start <= 1'b1; wr_is_page <= 1'b0;
          end
        end
      end else begin
        if (clk_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sr   <= {rx_sr[5:0], mosi_s};
          if (st == ST_SRFULL) st <= ST_IGN;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              if (busy && rx_byte != OP_STAT_RD) st <= ST_IGN;
              else begin
                case (rx_byte)
                  OP_WEL_SET: begin wel <= 1'b1; st <= ST_IGN; end
                  OP_WEL_CLR: begin wel <= 1'b0; st <= ST_IGN; end
                  OP_STAT_RD: begin st <= ST_STAT; tx_byte <= status; end
                  OP_STAT_WR: st <= wel ? ST_SRDAT : ST_IGN;
                  OP_MEM_RD:  begin st <= ST_AHI; is_rd <= 1'b1; end
                  OP_MEM_WR: begin
                    st <= wel ? ST_AHI : ST_IGN;
                    is_rd <= 1'b0; pg_vld <= '0; page_got <= 1'b0;
                  end
                  default: st <= ST_IGN;
                endcase
              end
            end
            ST_AHI: begin ahi <= rx_byte[HI_W-1:0]; st <= ST_ALO; end
            ST_ALO: begin
              if (is_rd) begin
                addr <= full_a; rd_req <= 1'b1; st <= ST_RDAT;
              end else begin
                pg_base <= full_a[ADDR_W-1:PAGE_W];
                pg_col  <= full_a[PAGE_W-1:0];
                st      <= ST_WDAT;
              end
            end
            ST_RDAT: begin addr <= addr + 1'b1; rd_req <= 1'b1; end
            ST_WDAT: begin
              pg_vld[pg_col] <= 1'b1; pg_col <= pg_col + 1'b1; page_got <= 1'b1;
            end
            ST_SRDAT: begin sr_new <= rx_byte[7:2]; st <= ST_SRFULL; end
            ST_STAT:  tx_byte <= status;
            default: ;
          endcase
        end
      end
      if (wr_done) begin
        wel <= 1'b0;
        if (!wr_is_page) sr_user <= sr_new;
      end
    end
  end

  // page buffer, filled per data byte and drained by the write timer
  logic [7:0] pg_buf [PAGE_BYTES];
  always_ff @(posedge clk) begin
    if (byte_done && st == ST_WDAT) pg_buf[pg_col] <= rx_byte;
  end

  spi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(wr_start), .busy(busy), .step(step), .done(wr_done)
  );

  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  assign cidx     = step[PAGE_W-1:0];
  assign ram_we   = busy && wr_is_page && (int'(step) < PAGE_BYTES) && pg_vld[cidx];
  assign ram_addr = ram_we ? {pg_base, cidx} : addr;

  spi_mem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(pg_buf[cidx]), .rdata(ram_rdata)
  );

  // registered serial output
  logic so_q, so_oe_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      so_q    <= 1'b0;
      so_oe_q <= 1'b0;
    end else begin
      so_oe_q <= !sel_s && !paused && (st == ST_STAT || st == ST_RDAT);
      if (clk_fall) so_q <= tx_byte[~bit_cnt];
    end
  end
  assign miso    = so_q;
  assign miso_oe = so_oe_q;

  // R11: a pause turns the output off and freezes the bit position
  p_pause_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    paused |=> !miso_oe) else $error("output driven while paused");
  p_pause_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (paused && !sel_s) |=> $stable(bit_cnt)) else $error("bit counter moved while paused");
  // R7: a finished programming cycle leaves the latch clear
  p_wel_clear_r7: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wel) else $error("latch still set after programming");
  // R3: programming only ever begins with the latch set
  p_start_wel_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)) else $error("programming without latch");
  // R8: commands other than status read are refused while busy
  p_busy_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && byte_done && st == ST_OPC && rx_byte != OP_STAT_RD) |=> (st == ST_IGN))
    else $error("command accepted while busy");
  // R10: the ignore state never drives the output
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && st == ST_IGN) |=> !miso_oe) else $error("output on in ignore state");
  // R9: a deselect off a byte boundary never starts programming
  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && bit_cnt != 3'd0) |=> !wr_start) else $error("partial byte started a write");
endmodule

// File: tb/spi_eeprom_ctl_tb_top.sv
module spi_eeprom_ctl_tb_top;
  localparam int HALF = 8;
  localparam int WRC  = 4000;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, ser_clk = 1'b0, mosi = 1'b0, pause_n = 1'b1;
  logic miso, miso_oe;
  int nchk = 0, nfail = 0;
  bit oe_seen, pause_oe, finished = 1'b0;

  always #10 clk = ~clk;

  spi_eeprom_ctl #(.ADDR_W(10), .PAGE_W(5), .WR_CYCLES(WRC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .mosi(mosi),
    .pause_n(pause_n), .miso(miso), .miso_oe(miso_oe)
  );

  typedef struct packed { logic rd; logic [15:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 16'h0010, 8'hA5}, '{1'b0, 16'h0011, 8'h3C},
    '{1'b1, 16'h0010, 8'hA5}, '{1'b1, 16'h0011, 8'h3C},
    '{1'b0, 16'h0123, 8'h7E}, '{1'b1, 16'h0123, 8'h7E},
    '{1'b0, 16'h2410, 8'h5A}, '{1'b1, 16'h0010, 8'h5A}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbyte_h(input logic [7:0] b, input int hat, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      if (i == hat) begin
        pause_n = 1'b0;
        tick(HALF);
        for (int k = 0; k < 3; k++) begin
          mosi = ~mosi;
          tick(HALF);
          if (miso_oe) pause_oe = 1'b1;
          ser_clk = 1'b1;
          tick(HALF);
          if (miso_oe) pause_oe = 1'b1;
          ser_clk = 1'b0;
        end
        tick(HALF);
        pause_n = 1'b1;
        tick(HALF);
      end
      mosi = b[i];
      tick(HALF);
      if (miso_oe) oe_seen = 1'b1;
      r[i] = miso;
      ser_clk = 1'b1;
      tick(HALF);
      ser_clk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    xbyte_h(b, 99, r);
  endtask

  task automatic sel();
    sel_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    sel_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xbyte(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xbyte(8'h05, r); xbyte(8'h00, s); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int n = 0; n < 60; n++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    cmd1(8'h06);
    sel(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r); xbyte(d, r); desel();
    wait_ready();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] r;
    sel(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r); xbyte(8'h00, d); desel();
  endtask

  // watchdog
  initial begin
    tick(190000);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, d2, r;
    tick(5);
    rst = 1'b0;
    tick(5);

    // R1 reset state
    chk("R1 oe after reset", miso_oe, 1'b0);
    rdsr(s);
    chk("R1 status after reset", s, 8'h00);

    // table: writes and reads, R4 address truncation, R5 storage
    foreach (VECS[i]) begin
      if (VECS[i].rd) begin
        read1(VECS[i].a, d);
        chk("R5/R4 table read", d, VECS[i].d);
      end else begin
        write1(VECS[i].a, VECS[i].d);
      end
    end

    // R2 latch set/clear
    cmd1(8'h06); rdsr(s);
    chk("R2 latch set", s, 8'h02);
    rdsr(s);
    chk("R2 status repeat", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk("R2 latch clear", s, 8'h00);

    // R3 writes without latch are dropped
    sel(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h11, r); xbyte(8'hFF, r); desel();
    tick(WRC + 100);
    read1(16'h0011, d);
    chk("R3 data write dropped", d, 8'h3C);
    sel(); xbyte(8'h01, r); xbyte(8'hFC, r); desel();
    tick(WRC + 100);
    rdsr(s);
    chk("R3 status write dropped", s, 8'h00);

    // R4 sequential read
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r);
    xbyte(8'h00, d); xbyte(8'h00, d2); desel();
    chk("R4 seq byte0", d, 8'h5A);
    chk("R4 seq byte1", d2, 8'h3C);

    // R6 page wrap: start at column 30 of page 0x40..0x5F
    cmd1(8'h06);
    sel(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h5E, r);
    xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r); xbyte(8'h44, r); desel();

    // R8 busy behaviour during this programming cycle
    rdsr(s);
    chk("R8 busy and latch", s, 8'h03);
    oe_seen = 1'b0;
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r); xbyte(8'h00, r); desel();
    chk("R8 read refused while busy", oe_seen, 1'b0);
    sel(); xbyte(8'h02, r); xbyte(8'h01, r); xbyte(8'h23, r); xbyte(8'h00, r); desel();
    wait_ready();
    rdsr(s);
    chk("R7 latch self-cleared", s, 8'h00);
    read1(16'h0123, d);
    chk("R8 write during busy ignored", d, 8'h7E);
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h5E, r);
    xbyte(8'h00, d); xbyte(8'h00, d2); desel();
    chk("R6 col30", d, 8'h11);
    chk("R6 col31", d2, 8'h22);
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h40, r);
    xbyte(8'h00, d); xbyte(8'h00, d2); desel();
    chk("R6 wrapped col0", d, 8'h33);
    chk("R6 wrapped col1", d2, 8'h44);

    // R9 abort on partial byte
    cmd1(8'h06);
    sel(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h10, r); xbyte(8'h77, r);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; tick(HALF); ser_clk = 1'b1; tick(HALF); ser_clk = 1'b0;
    end
    desel();
    rdsr(s);
    chk("R9 no busy, latch kept", s, 8'h02);
    tick(WRC + 100);
    read1(16'h0010, d);
    chk("R9 data unchanged", d, 8'h5A);
    cmd1(8'h04);

    // R10 unknown command keeps output off
    oe_seen = 1'b0;
    sel(); xbyte(8'hAB, r); xbyte(8'h05, r); xbyte(8'h03, r); desel();
    chk("R10 unknown opcode quiet", oe_seen, 1'b0);

    // R11 pause in address byte (junk clocks ignored) and in data byte
    pause_oe = 1'b0;
    sel(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte_h(8'h11, 4, r);
    xbyte_h(8'h00, 4, d); desel();
    chk("R11 data after pauses", d, 8'h3C);
    chk("R11 output off while paused", pause_oe, 1'b0);

    // R12 status write
    cmd1(8'h06);
    sel(); xbyte(8'h01, r); xbyte(8'hA8, r); desel();
    wait_ready();
    rdsr(s);
    chk("R12/R7 status written, latch clear", s, 8'hA8);

    // R1 reset clears latch and status
    cmd1(8'h06);
    rst = 1'b1; tick(3); rst = 1'b0; tick(5);
    chk("R1 oe after second reset", miso_oe, 1'b0);
    rdsr(s);
    chk("R1 status after second reset", s, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule